// File: doc/BRIEF.md
# Speculative Store Buffer with Load Forwarding

This block keeps stores that have been decoded but not yet retired in a small ring of slots, so that memory is never written by a store that might still be squashed. The front end takes a slot for each store in program order and receives its slot number. Execution later fills that slot in two independent steps, in either order: an address step and a data step. Once the store becomes the oldest instruction in the machine and both halves are present, a commit marks the slot non-speculative. Committed slots then drain to a cache write port, oldest first, one per cycle. A squash discards a speculative slot together with every younger slot.

Loads query the ring at the same time as the cache. The load gives its address, the cache data for that address, and a snapshot of the allocation pointer taken when the load was decoded. Only stores older than that snapshot are searched. The youngest matching store supplies the data. If no store matches, the cache data passes through. If the answer is not yet known, the block reports a stall instead.

Top module: `ssb_top`

## Requirements
- R1: `alloc_slot` is the low part of `alloc_ptr`. The pointer advances by one for each accepted allocation, so slot numbers are handed out in ring order. `alloc_ok` is low whenever DEPTH slots are occupied or `abort_req` is high, and a request made while `alloc_ok` is low has no effect.
- R2: The address write and the data write to an allocated speculative slot may arrive in either order. The slot becomes ready to commit only after both have arrived.
- R3: A commit takes effect only when `commit_slot` names the oldest uncommitted slot and that slot holds both its address and its data. Any other commit request is ignored, and the cache port stays idle as a result.
- R4: Committed slots appear on the cache port in program order. While `cw_valid` is high and `cw_ready` is low, the address and data on the port hold steady. Each accepted write frees its slot.
- R5: An abort of a speculative slot removes that slot and every younger slot. The next allocation then reuses the aborted slot number.
- R6: When older stores match the load, the youngest of them supplies `ld_data` with `ld_hit` high, even though cache data is also present.
- R7: When no older store matches and there is no stall, `ld_hit` is low and `ld_data` equals `ld_cache_data`.
- R8: `ld_stall` is high, and `ld_hit` is low, if any older store still lacks its address, or if the youngest matching store still lacks its data.
- R9: A store matches a load when the two addresses agree in their low MATCH_BITS (12) bits. The upper bits are not compared.
- R10: Only slots between the oldest slot and the load's pointer snapshot `ld_ptr` take part in the search. Stores allocated after that snapshot are ignored.
- R11: After reset the ring is empty: `alloc_ok` is 1, `alloc_ptr` is 0 and `cw_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_req | input | 1 | Request a slot for a newly decoded store |
| alloc_ok | output | 1 | Allocation would be accepted this cycle |
| alloc_slot | output | IW | Slot number given to the next allocation |
| alloc_ptr | output | IW+1 | Allocation pointer with wrap bit (snapshot source for loads) |
| addr_we | input | 1 | Address step completed |
| addr_slot | input | IW | Slot targeted by the address step |
| addr_val | input | AW | Store address |
| data_we | input | 1 | Data step completed |
| data_slot | input | IW | Slot targeted by the data step |
| data_val | input | DW | Store data |
| commit_req | input | 1 | Store named by commit_slot is the oldest instruction |
| commit_slot | input | IW | Slot to commit |
| commit_ready | output | 1 | Oldest uncommitted slot holds both address and data |
| abort_req | input | 1 | Squash from the given slot onward |
| abort_slot | input | IW | Oldest slot to squash |
| ld_ptr | input | IW+1 | Allocation pointer snapshot of the load |
| ld_addr | input | AW | Load address |
| ld_cache_data | input | DW | Data the cache returns for the load |
| ld_hit | output | 1 | Data comes from a buffered store |
| ld_stall | output | 1 | Load must retry later |
| ld_data | output | DW | Load result |
| cw_valid | output | 1 | A committed store is offered to the cache |
| cw_addr | output | AW | Address of the offered store |
| cw_data | output | DW | Data of the offered store |
| cw_ready | input | 1 | Cache accepts the offered store |

## Verification
The assertions assume that at most one commit or abort is presented per cycle. They also assume that `ld_ptr` lies between the oldest slot and the current allocation pointer, which is always true for a load decoded after the stores it follows. The random stimulus draws slot numbers and load snapshots from a reference model of the ring, so the snapshots always fall inside that window. Commits and aborts sometimes name wrong or committed slots on purpose, which the block must ignore. Load addresses come from a few low-bit patterns with random upper bits, so partial matches, several matching stores and unknown addresses all occur often.

// File: rtl/ssb_pkg.sv
package ssb_pkg;
    localparam int AW = 32;
    localparam int DW = 32;

    typedef struct packed {
        logic          valid;
        logic          spec;
        logic          has_addr;
        logic          has_data;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
    } sb_entry_t;
endpackage

// File: rtl/ssb_fwd_search.sv
module ssb_fwd_search
    import ssb_pkg::*;
#(
    parameter  int DEPTH      = 8,
    parameter  int MATCH_BITS = 12,
    localparam int IW         = $clog2(DEPTH),
    localparam int PW         = IW + 1
) (
    input  sb_entry_t [DEPTH-1:0] ent,
    input  logic [IW-1:0]         head_idx,
    input  logic [PW-1:0]         older_cnt,
    input  logic [AW-1:0]         ld_addr,
    output logic                  hit,
    output logic                  stall,
    output logic [DW-1:0]         data
);
    logic found;
    logic unknown;
    logic sel_has_data;

    // walk oldest to youngest; a later match overrides an earlier one
    always_comb begin
        found        = 1'b0;
        unknown      = 1'b0;
        sel_has_data = 1'b0;
        data         = '0;
        for (int k = 0; k < DEPTH; k++) begin
            if (PW'(k) < older_cnt && ent[IW'(head_idx + IW'(k))].valid) begin
                if (!ent[IW'(head_idx + IW'(k))].has_addr) begin
                    unknown = 1'b1;
                end else if (ent[IW'(head_idx + IW'(k))].addr[MATCH_BITS-1:0]
                             == ld_addr[MATCH_BITS-1:0]) begin
                    found        = 1'b1;
                    sel_has_data = ent[IW'(head_idx + IW'(k))].has_data;
                    data         = ent[IW'(head_idx + IW'(k))].data;
                end
            end
        end
        stall = unknown | (found & ~sel_has_data);
        hit   = found & ~stall;
    end
endmodule

// File: rtl/ssb_top.sv
module ssb_top
    import ssb_pkg::*;
#(
    parameter  int DEPTH      = 8,
    parameter  int MATCH_BITS = 12,
    localparam int IW         = $clog2(DEPTH),
    localparam int PW         = IW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          alloc_req,
    output logic          alloc_ok,
    output logic [IW-1:0] alloc_slot,
    output logic [PW-1:0] alloc_ptr,
    input  logic          addr_we,
    input  logic [IW-1:0] addr_slot,
    input  logic [AW-1:0] addr_val,
    input  logic          data_we,
    input  logic [IW-1:0] data_slot,
    input  logic [DW-1:0] data_val,
    input  logic          commit_req,
    input  logic [IW-1:0] commit_slot,
    output logic          commit_ready,
    input  logic          abort_req,
    input  logic [IW-1:0] abort_slot,
    input  logic [PW-1:0] ld_ptr,
    input  logic [AW-1:0] ld_addr,
    input  logic [DW-1:0] ld_cache_data,
    output logic          ld_hit,
    output logic          ld_stall,
    output logic [DW-1:0] ld_data,
    output logic          cw_valid,
    output logic [AW-1:0] cw_addr,
    output logic [DW-1:0] cw_data,
    input  logic          cw_ready
);
    // head: oldest slot, cptr: oldest uncommitted slot, tail: next free slot
    typedef struct packed {
        sb_entry_t [DEPTH-1:0] ent;
        logic [PW-1:0]         head;
        logic [PW-1:0]         cptr;
        logic [PW-1:0]         tail;
    } sb_state_t;

    sb_state_t     s_d, s_q;
    logic [PW-1:0] occ_d;
    logic [IW-1:0] hidx_d, cidx_d, tidx_d, aoff_d;
    logic          full_d, commit_go_d, abort_go_d;
    logic          fwd_hit, fwd_stall;
    logic [DW-1:0] fwd_data;

    always_comb begin
        s_d    = s_q;
        hidx_d = s_q.head[IW-1:0];
        cidx_d = s_q.cptr[IW-1:0];
        tidx_d = s_q.tail[IW-1:0];
        occ_d  = s_q.tail - s_q.head;
        full_d = (occ_d == PW'(DEPTH));

        alloc_ok     = !full_d && !abort_req;
        alloc_slot   = tidx_d;
        alloc_ptr    = s_q.tail;
        commit_ready = (s_q.cptr != s_q.tail) && s_q.ent[cidx_d].has_addr
                       && s_q.ent[cidx_d].has_data;
        commit_go_d  = commit_req && commit_ready && (commit_slot == cidx_d);
        abort_go_d   = abort_req && s_q.ent[abort_slot].valid
                       && s_q.ent[abort_slot].spec && !commit_go_d;
        aoff_d       = abort_slot - hidx_d;

        cw_valid = (s_q.head != s_q.cptr);
        cw_addr  = s_q.ent[hidx_d].addr;
        cw_data  = s_q.ent[hidx_d].data;

        // execution results land only in live speculative slots
        if (addr_we && s_q.ent[addr_slot].valid && s_q.ent[addr_slot].spec) begin
            s_d.ent[addr_slot].addr     = addr_val;
            s_d.ent[addr_slot].has_addr = 1'b1;
        end
        if (data_we && s_q.ent[data_slot].valid && s_q.ent[data_slot].spec) begin
            s_d.ent[data_slot].data     = data_val;
            s_d.ent[data_slot].has_data = 1'b1;
        end

        if (commit_go_d) begin
            s_d.ent[cidx_d].spec = 1'b0;
            s_d.cptr             = s_q.cptr + PW'(1);
        end

        if (abort_go_d) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (IW'(IW'(i) - hidx_d) >= aoff_d) begin
                    s_d.ent[i].valid = 1'b0;
                end
            end
            s_d.tail = s_q.head + {1'b0, aoff_d};
        end

        if (cw_valid && cw_ready) begin
            s_d.ent[hidx_d].valid = 1'b0;
            s_d.head              = s_q.head + PW'(1);
        end

        if (alloc_req && alloc_ok) begin
            s_d.ent[tidx_d]       = '0;
            s_d.ent[tidx_d].valid = 1'b1;
            s_d.ent[tidx_d].spec  = 1'b1;
            s_d.tail              = s_q.tail + PW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    ssb_fwd_search #(
        .DEPTH      (DEPTH),
        .MATCH_BITS (MATCH_BITS)
    ) i_search (
        .ent       (s_q.ent),
        .head_idx  (s_q.head[IW-1:0]),
        .older_cnt (ld_ptr - s_q.head),
        .ld_addr   (ld_addr),
        .hit       (fwd_hit),
        .stall     (fwd_stall),
        .data      (fwd_data)
    );

    assign ld_hit   = fwd_hit;
    assign ld_stall = fwd_stall;
    assign ld_data  = fwd_hit ? fwd_data : ld_cache_data;

    AST_ALLOC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_req && alloc_ok) |=> alloc_ptr == $past(alloc_ptr) + PW'(1)); // R1
    AST_DRAIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cw_valid && !cw_ready) |=> cw_valid && $stable(cw_addr) && $stable(cw_data)); // R4
    AST_EMPTY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_ptr == s_q.head) |-> !cw_valid); // R11
    AST_ABORT_REWIND: assert property (@(posedge clk) disable iff (!rst_n)
        abort_go_d |=> alloc_slot == $past(abort_slot)); // R5
    AST_COMMIT_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        commit_go_d |=> s_q.cptr == $past(s_q.cptr) + PW'(1)); // R3
    AST_HIT_NOT_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        !(ld_hit && ld_stall)); // R8
endmodule

// File: tb/test_ssb_top.sv
`timescale 1ns/1ps
module test_ssb_top;
    localparam int IW = 3;
    localparam int PW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          alloc_req = 0, addr_we = 0, data_we = 0, commit_req = 0, abort_req = 0;
    logic          cw_ready = 0;
    logic [IW-1:0] addr_slot = 0, data_slot = 0, commit_slot = 0, abort_slot = 0;
    logic [31:0]   addr_val = 0, data_val = 0, ld_addr = 0, ld_cache_data = 0;
    logic [PW-1:0] ld_ptr = 0;
    logic          alloc_ok, commit_ready, ld_hit, ld_stall, cw_valid;
    logic [IW-1:0] alloc_slot;
    logic [PW-1:0] alloc_ptr;
    logic [31:0]   ld_data, cw_addr, cw_data;

    int errors = 0;
    int checks = 0;

    // reference ring
    bit        mv[8], ms[8], mha[8], mhd[8];
    bit [31:0] maddr[8], mdata[8];
    bit [3:0]  mh, mc, mt;

    always #4 clk = ~clk;

    ssb_top i_ssb_top (
        .clk(clk), .rst_n(rst_n),
        .alloc_req(alloc_req), .alloc_ok(alloc_ok), .alloc_slot(alloc_slot), .alloc_ptr(alloc_ptr),
        .addr_we(addr_we), .addr_slot(addr_slot), .addr_val(addr_val),
        .data_we(data_we), .data_slot(data_slot), .data_val(data_val),
        .commit_req(commit_req), .commit_slot(commit_slot), .commit_ready(commit_ready),
        .abort_req(abort_req), .abort_slot(abort_slot),
        .ld_ptr(ld_ptr), .ld_addr(ld_addr), .ld_cache_data(ld_cache_data),
        .ld_hit(ld_hit), .ld_stall(ld_stall), .ld_data(ld_data),
        .cw_valid(cw_valid), .cw_addr(cw_addr), .cw_data(cw_data), .cw_ready(cw_ready)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic void ref_lookup(output bit h, output bit s, output bit [31:0] d);
        bit [3:0] cnt = ld_ptr - mh;
        bit found = 0, unk = 0, hd = 0;
        d = ld_cache_data;
        for (int k = 0; k < 8; k++) begin
            bit [2:0] ix = mh[2:0] + 3'(k);
            if (k < int'(cnt) && mv[ix]) begin
                if (!mha[ix]) unk = 1;
                else if (maddr[ix][11:0] == ld_addr[11:0]) begin
                    found = 1; hd = mhd[ix]; d = mdata[ix];
                end
            end
        end
        s = unk | (found & !hd);
        h = found & !s;
        if (!h) d = ld_cache_data;
    endfunction

    task automatic idle();
        alloc_req = 0; addr_we = 0; data_we = 0; commit_req = 0; abort_req = 0;
    endtask

    // inputs already driven after a falling edge; check, clock, update model
    task automatic step();
        bit h, s;
        bit [31:0] d;
        bit [3:0] occ;
        bit drain, cgo;
        bit [2:0] ci, off;
        #1;
        occ = mt - mh;
        chk(alloc_ok == (occ < 8 && !abort_req), "R1 alloc_ok", alloc_ok, (occ < 8 && !abort_req));
        chk(alloc_ptr == mt, "R1 alloc_ptr", alloc_ptr, mt);
        chk(cw_valid == (mh != mc), "R4 cw_valid", cw_valid, (mh != mc));
        if (mh != mc) begin
            chk(cw_addr == maddr[mh[2:0]], "R4 cw_addr", cw_addr, maddr[mh[2:0]]);
            chk(cw_data == mdata[mh[2:0]], "R4 cw_data", cw_data, mdata[mh[2:0]]);
        end
        ref_lookup(h, s, d);
        chk(ld_stall == s, "R8 ld_stall", ld_stall, s);
        chk(ld_hit == h, h ? "R6 ld_hit" : "R7 ld_hit", ld_hit, h);
        chk(ld_data == d, h ? "R6 ld_data" : "R7 ld_data", ld_data, d);
        @(posedge clk);
        drain = (mh != mc) && cw_ready;
        if (addr_we && mv[addr_slot] && ms[addr_slot]) begin
            maddr[addr_slot] = addr_val; mha[addr_slot] = 1;
        end
        if (data_we && mv[data_slot] && ms[data_slot]) begin
            mdata[data_slot] = data_val; mhd[data_slot] = 1;
        end
        ci  = mc[2:0];
        cgo = commit_req && (mc != mt) && mha[ci] && mhd[ci] && commit_slot == ci;
        if (cgo) begin ms[ci] = 0; mc++; end
        if (abort_req && mv[abort_slot] && ms[abort_slot] && !cgo) begin
            off = abort_slot - mh[2:0];
            for (int k = 0; k < 8; k++)
                if (3'(k) - mh[2:0] >= off) mv[k] = 0;
            mt = mh + {1'b0, off};
        end
        if (drain) begin mv[mh[2:0]] = 0; mh++; end
        if (alloc_req && occ < 8 && !abort_req) begin
            mv[mt[2:0]] = 1; ms[mt[2:0]] = 1; mha[mt[2:0]] = 0; mhd[mt[2:0]] = 0;
            maddr[mt[2:0]] = 0; mdata[mt[2:0]] = 0;
            mt++;
        end
        @(negedge clk);
        idle();
    endtask

    task automatic look(input bit [3:0] p, input bit [31:0] a, input bit [31:0] cd);
        ld_ptr = p; ld_addr = a; ld_cache_data = cd; #1;
    endtask

    initial begin
        #(200000 * 8);
        errors++;
        $display("FAIL watchdog: actual=hung expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        mh = 0; mc = 0; mt = 0;
        for (int i = 0; i < 8; i++) begin mv[i] = 0; ms[i] = 0; mha[i] = 0; mhd[i] = 0; maddr[i] = 0; mdata[i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        chk(alloc_ok == 1 && alloc_ptr == 0 && cw_valid == 0, "R11 reset state",
            {alloc_ok, alloc_ptr, cw_valid}, {1'b1, 4'd0, 1'b0});
        // three stores; data before address on slot 1
        for (int i = 0; i < 3; i++) begin alloc_req = 1; step(); end
        data_we = 1; data_slot = 1; data_val = 32'h2222_2222; step();
        chk(commit_ready == 0, "R2 data alone not ready", commit_ready, 0);
        addr_we = 1; addr_slot = 1; addr_val = 32'hABC0_0100; step();
        addr_we = 1; addr_slot = 0; addr_val = 32'h0000_0100; step();
        data_we = 1; data_slot = 0; data_val = 32'h1111_1111; step();
        chk(commit_ready == 1, "R2 both halves present", commit_ready, 1);
        addr_we = 1; addr_slot = 2; addr_val = 32'h0000_0200; step();
        look(4'd3, 32'h5555_5100, 32'hCAFE_0000);
        chk(ld_hit && ld_data == 32'h2222_2222, "R6 R9 youngest partial match", ld_data, 32'h2222_2222);
        look(4'd1, 32'h0000_0100, 32'hCAFE_0000);
        chk(ld_hit && ld_data == 32'h1111_1111, "R10 snapshot limits search", ld_data, 32'h1111_1111);
        look(4'd3, 32'h0000_0200, 32'hCAFE_0000);
        chk(ld_stall && !ld_hit, "R8 match without data", {ld_stall, ld_hit}, 2'b10);
        look(4'd3, 32'h0000_0300, 32'hCAFE_0001);
        chk(!ld_hit && !ld_stall && ld_data == 32'hCAFE_0001, "R7 miss uses cache", ld_data, 32'hCAFE_0001);
        // wrong-slot commit is ignored
        commit_req = 1; commit_slot = 1; step();
        #1 chk(cw_valid == 0, "R3 out-of-order commit ignored", cw_valid, 0);
        commit_req = 1; commit_slot = 0; step();
        #1 chk(cw_valid && cw_addr == 32'h0000_0100, "R4 committed store offered", cw_addr, 32'h100);
        step(); step();
        // squash slot 1 and younger
        abort_req = 1; abort_slot = 1; step();
        #1 chk(alloc_slot == 1, "R5 abort rewinds allocation", alloc_slot, 1);
        cw_ready = 1; step(); cw_ready = 0;
        // fill the ring
        for (int i = 0; i < 9; i++) begin alloc_req = 1; step(); end
        #1 chk(alloc_ok == 0, "R1 full refuses allocation", alloc_ok, 0);
        abort_req = 1; abort_slot = mh[2:0]; step();
        #1 chk(alloc_ptr == mh, "R5 abort of oldest empties ring", alloc_ptr, mh);

        // random phase
        void'($urandom(32'd1234));
        for (int n = 0; n < 4000; n++) begin
            int op;
            bit [3:0] occ;
            occ = mt - mh;
            op = $urandom_range(0, 9);
            cw_ready = ($urandom_range(0, 2) != 0);
            case (op)
                0, 1: alloc_req = 1;
                2, 3: begin
                    addr_we = 1; addr_slot = 3'($urandom_range(0, 7));
                    addr_val = {$urandom(), 12'h0} | 32'($urandom_range(0, 3) * 16);
                end
                4, 5: begin data_we = 1; data_slot = 3'($urandom_range(0, 7)); data_val = $urandom(); end
                6, 7: begin
                    commit_req = 1;
                    commit_slot = ($urandom_range(0, 3) == 0) ? 3'($urandom_range(0, 7)) : mc[2:0];
                end
                8: if ($urandom_range(0, 3) == 0) begin
                    abort_req = 1; abort_slot = 3'($urandom_range(0, 7));
                end
                default: ;
            endcase
            ld_ptr = mh + 4'($urandom_range(0, int'(occ)));
            ld_addr = {$urandom(), 12'h0} | 32'($urandom_range(0, 3) * 16);
            ld_cache_data = $urandom();
            step();
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule